// File: doc/BRIEF.md
# Four-Bank Open-Row Manager

This block sits between an SDRAM request generator and the command and transfer stages of a memory controller. It keeps a record for each of four banks: whether a row is open and which one. Every incoming request carries a bank, row, column, length and direction. The block compares the request against that bank's record and opens rows only when needed. On a page hit it forwards the request at once. On a miss in an open bank it closes the old row and then opens the new one. For a bank that is closed, it opens the row directly. Only after these steps does the request go to the transfer controller.

Each bank has its own down-counters for the row-active window, the precharge recovery, the activate-to-access delay and the write recovery. One shared counter spaces Active commands across all banks. Every command is issued in the first cycle that all applicable timers allow. An external precharge-all can be reported through a dedicated input, which marks every bank closed and restarts their precharge recovery. The block handles one request at a time. Refresh, initialization and data movement are left to neighbouring blocks. The close-all input is meant to be pulsed while no request is in flight.

Top module: `sdr_bank_mgr`

## Requirements
- R1: Each of the four banks keeps its own open flag and open row; opening or closing one bank never changes the record of another, so a row opened earlier in bank b is still a hit after traffic to other banks.
- R2: A request to an open bank whose open row equals the requested row issues no command and is offered to transfer control in the cycle after acceptance (subject to R4).
- R3: A request to an open bank with a different row issues exactly one Precharge to that bank, then exactly one Active carrying the new row; the Active comes at least tRP cycles after the Precharge.
- R4: A request is offered to transfer control no earlier than tRCD cycles after the Active of its bank, and is handed over in the first cycle in which that holds, xfer_ready_i is high and the earlier steps are done.
- R5: A Precharge to a bank is never issued earlier than tRAS cycles after that bank's Active.
- R6: Two Active commands, to any banks, are at least tRC cycles apart.
- R7: Commands use ras_n/cas_n/we_n: Active = 0,1,1 with cmd_addr_o = row and cmd_bank_o = bank; Precharge = 0,1,0 with cmd_addr_o all zero (single bank, address bit 10 low); with cmd_valid_o low the lines read 1,1,1. Each command is issued in the earliest cycle its timers allow.
- R8: A request to a closed bank issues exactly one Active and no Precharge.
- R9: After a write request is handed to transfer control, no Precharge to that bank is issued earlier than tWR cycles later.
- R10: A one-cycle pulse on close_all_i marks every bank closed; the next Active to any bank is no earlier than tRP cycles after the pulse.
- R11: Each timing field is a 4-bit cycle count; a programmed value of 0 behaves as 1.
- R12: req_ready_o is high only while no request is held; the forwarded bank, column, length and write flag equal those accepted.
- R13: After reset all banks are closed, req_ready_o is high and no command or transfer is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_tras_i | input | TM_W | Active-to-Precharge minimum, cycles |
| cfg_trp_i | input | TM_W | Precharge-to-Active minimum, cycles |
| cfg_trcd_i | input | TM_W | Active-to-access minimum, cycles |
| cfg_trc_i | input | TM_W | Active-to-Active minimum across banks, cycles |
| cfg_twr_i | input | TM_W | Write-to-Precharge minimum, cycles |
| close_all_i | input | 1 | External precharge-all happened; close every bank |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted when high with req_valid_i |
| req_bank_i | input | BA_W | Request bank |
| req_row_i | input | ROW_W | Request row |
| req_col_i | input | COL_W | Request start column |
| req_len_i | input | LEN_W | Request length |
| req_write_i | input | 1 | 1 = write, 0 = read |
| cmd_valid_o | output | 1 | Command issued this cycle |
| cmd_ras_n_o | output | 1 | Row strobe, active low |
| cmd_cas_n_o | output | 1 | Column strobe, active low |
| cmd_we_n_o | output | 1 | Write enable, active low |
| cmd_bank_o | output | BA_W | Command bank |
| cmd_addr_o | output | ROW_W | Command address |
| xfer_valid_o | output | 1 | Request offered to transfer control |
| xfer_ready_i | input | 1 | Transfer control takes the request |
| xfer_bank_o | output | BA_W | Forwarded bank |
| xfer_col_o | output | COL_W | Forwarded column |
| xfer_len_o | output | LEN_W | Forwarded length |
| xfer_write_o | output | 1 | Forwarded direction |

## Verification
The bench sweeps six timing configurations, including all zeros and a stalling transfer port. In each one it interleaves requests to a few rows per bank, so that hits, open misses and closed-bank opens all occur, along with a close-all pulse. For every request it works out the exact cycle of each Precharge, Active and handover from the timing history. An off-by-one timer would move one of those cycles and be seen at once. A missing tWR or tRAS guard would precharge too early after a write or an Active. A global tRC counter that is reset per bank would let Actives crowd together. A stale open flag after close-all would skip the Active, and a wrong row compare would add or drop a Precharge.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_ACT, ST_FWD} sbm_state_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sbm_cmd_t;

  localparam sbm_cmd_t CMD_NOP = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sbm_cmd_t CMD_ACT = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
  localparam sbm_cmd_t CMD_PRE = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
endpackage

// File: rtl/sbm_gap_timer.sv
// Minimum-spacing counter: after load at cycle t, ok_o rises at cycle t+max(val,1).
module sbm_gap_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         ok_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign ok_o = (cnt_q <= W'(1));
endmodule

// File: rtl/sbm_bank_slot.sv
module sbm_bank_slot #(
  parameter int ROW_W = 12,
  parameter int TM_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             wr_done_i,
  input  logic             close_all_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [TM_W-1:0]  tras_i,
  input  logic [TM_W-1:0]  trp_i,
  input  logic [TM_W-1:0]  trcd_i,
  input  logic [TM_W-1:0]  twr_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             pre_ok_o,
  output logic             act_ok_o,
  output logic             fwd_ok_o
);
  logic ras_ok, wr_ok;

  // Active wins over a simultaneous close for its own bank
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o <= 1'b0;
      row_o  <= '0;
    end else if (act_i) begin
      open_o <= 1'b1;
      row_o  <= row_i;
    end else if (pre_i || close_all_i) begin
      open_o <= 1'b0;
    end
  end

  sbm_gap_timer #(.W(TM_W)) u_ras (
    .clk_i, .rst_ni, .load_i(act_i), .val_i(tras_i), .ok_o(ras_ok));
  sbm_gap_timer #(.W(TM_W)) u_rcd (
    .clk_i, .rst_ni, .load_i(act_i), .val_i(trcd_i), .ok_o(fwd_ok_o));
  sbm_gap_timer #(.W(TM_W)) u_rp (
    .clk_i, .rst_ni, .load_i(pre_i || close_all_i), .val_i(trp_i), .ok_o(act_ok_o));
  sbm_gap_timer #(.W(TM_W)) u_wr (
    .clk_i, .rst_ni, .load_i(wr_done_i), .val_i(twr_i), .ok_o(wr_ok));

  assign pre_ok_o = ras_ok && wr_ok;
endmodule

// File: rtl/sbm_sequencer.sv
module sbm_sequencer
  import sbm_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int BA_W  = 2,
  parameter int ROW_W = 12,
  parameter int COL_W = 10,
  parameter int LEN_W = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [BA_W-1:0]             req_bank_i,
  input  logic [ROW_W-1:0]            req_row_i,
  input  logic [COL_W-1:0]            req_col_i,
  input  logic [LEN_W-1:0]            req_len_i,
  input  logic                        req_write_i,
  input  logic                        close_all_i,
  input  logic [BANKS-1:0]            bank_open_i,
  input  logic [BANKS-1:0][ROW_W-1:0] bank_row_i,
  input  logic [BANKS-1:0]            pre_ok_i,
  input  logic [BANKS-1:0]            act_ok_i,
  input  logic [BANKS-1:0]            fwd_ok_i,
  input  logic                        rc_ok_i,
  output logic                        issue_pre_o,
  output logic                        issue_act_o,
  output logic [BA_W-1:0]             sel_bank_o,
  output logic [ROW_W-1:0]            sel_row_o,
  output logic                        xfer_valid_o,
  input  logic                        xfer_ready_i,
  output logic [COL_W-1:0]            xfer_col_o,
  output logic [LEN_W-1:0]            xfer_len_o,
  output logic                        xfer_write_o,
  output logic                        wr_done_o
);
  sbm_state_e state_q, state_d;
  logic       accept, open_now, row_match;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_ready_o && req_valid_i;
  assign open_now    = bank_open_i[req_bank_i] && !close_all_i;
  assign row_match   = (bank_row_i[req_bank_i] == req_row_i);

  always_comb begin
    state_d      = state_q;
    issue_pre_o  = 1'b0;
    issue_act_o  = 1'b0;
    xfer_valid_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i)
                 state_d = !open_now ? ST_ACT : (row_match ? ST_FWD : ST_PRE);
      ST_PRE:  if (pre_ok_i[sel_bank_o]) begin
                 issue_pre_o = 1'b1;
                 state_d     = ST_ACT;
               end
      ST_ACT:  if (act_ok_i[sel_bank_o] && rc_ok_i) begin
                 issue_act_o = 1'b1;
                 state_d     = ST_FWD;
               end
      ST_FWD:  begin
                 xfer_valid_o = fwd_ok_i[sel_bank_o];
                 if (xfer_valid_o && xfer_ready_i) state_d = ST_IDLE;
               end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      sel_bank_o   <= '0;
      sel_row_o    <= '0;
      xfer_col_o   <= '0;
      xfer_len_o   <= '0;
      xfer_write_o <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        sel_bank_o   <= req_bank_i;
        sel_row_o    <= req_row_i;
        xfer_col_o   <= req_col_i;
        xfer_len_o   <= req_len_i;
        xfer_write_o <= req_write_i;
      end
    end
  end

  assign wr_done_o = xfer_valid_o && xfer_ready_i && xfer_write_o;
endmodule

// File: rtl/sdr_bank_mgr.sv
module sdr_bank_mgr
  import sbm_pkg::*;
#(
  parameter int  BANKS = 4,
  parameter int  ROW_W = 12,
  parameter int  COL_W = 10,
  parameter int  LEN_W = 4,
  parameter int  TM_W  = 4,
  localparam int BA_W  = $clog2(BANKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TM_W-1:0]  cfg_tras_i,
  input  logic [TM_W-1:0]  cfg_trp_i,
  input  logic [TM_W-1:0]  cfg_trcd_i,
  input  logic [TM_W-1:0]  cfg_trc_i,
  input  logic [TM_W-1:0]  cfg_twr_i,
  input  logic             close_all_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [BA_W-1:0]  req_bank_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic             req_write_i,
  output logic             cmd_valid_o,
  output logic             cmd_ras_n_o,
  output logic             cmd_cas_n_o,
  output logic             cmd_we_n_o,
  output logic [BA_W-1:0]  cmd_bank_o,
  output logic [ROW_W-1:0] cmd_addr_o,
  output logic             xfer_valid_o,
  input  logic             xfer_ready_i,
  output logic [BA_W-1:0]  xfer_bank_o,
  output logic [COL_W-1:0] xfer_col_o,
  output logic [LEN_W-1:0] xfer_len_o,
  output logic             xfer_write_o
);
  logic [BANKS-1:0]            bank_open, pre_ok, act_ok, fwd_ok;
  logic [BANKS-1:0][ROW_W-1:0] bank_row;
  logic                        rc_ok, issue_pre, issue_act, wr_done;
  logic [BA_W-1:0]             sel_bank;
  logic [ROW_W-1:0]            sel_row;
  sbm_cmd_t                    cmd;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit_bank;
    assign hit_bank = (sel_bank == BA_W'(b));
    sbm_bank_slot #(.ROW_W(ROW_W), .TM_W(TM_W)) u_slot (
      .clk_i, .rst_ni,
      .act_i      (issue_act && hit_bank),
      .pre_i      (issue_pre && hit_bank),
      .wr_done_i  (wr_done && hit_bank),
      .close_all_i,
      .row_i      (sel_row),
      .tras_i     (cfg_tras_i),
      .trp_i      (cfg_trp_i),
      .trcd_i     (cfg_trcd_i),
      .twr_i      (cfg_twr_i),
      .open_o     (bank_open[b]),
      .row_o      (bank_row[b]),
      .pre_ok_o   (pre_ok[b]),
      .act_ok_o   (act_ok[b]),
      .fwd_ok_o   (fwd_ok[b])
    );
  end

  // Active spacing is shared by all banks
  sbm_gap_timer #(.W(TM_W)) u_rc (
    .clk_i, .rst_ni, .load_i(issue_act), .val_i(cfg_trc_i), .ok_o(rc_ok));

  sbm_sequencer #(
    .BANKS(BANKS), .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W)
  ) u_seq (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_bank_i, .req_row_i, .req_col_i,
    .req_len_i, .req_write_i, .close_all_i,
    .bank_open_i (bank_open),
    .bank_row_i  (bank_row),
    .pre_ok_i    (pre_ok),
    .act_ok_i    (act_ok),
    .fwd_ok_i    (fwd_ok),
    .rc_ok_i     (rc_ok),
    .issue_pre_o (issue_pre),
    .issue_act_o (issue_act),
    .sel_bank_o  (sel_bank),
    .sel_row_o   (sel_row),
    .xfer_valid_o, .xfer_ready_i, .xfer_col_o, .xfer_len_o, .xfer_write_o,
    .wr_done_o   (wr_done)
  );

  always_comb begin
    if (issue_act)      cmd = CMD_ACT;
    else if (issue_pre) cmd = CMD_PRE;
    else                cmd = CMD_NOP;
  end

  assign cmd_valid_o = issue_act || issue_pre;
  assign cmd_ras_n_o = cmd.ras_n;
  assign cmd_cas_n_o = cmd.cas_n;
  assign cmd_we_n_o  = cmd.we_n;
  assign cmd_bank_o  = sel_bank;
  assign cmd_addr_o  = issue_act ? sel_row : '0;
  assign xfer_bank_o = sel_bank;
endmodule

// File: rtl/sbm_checker.sv
module sbm_checker #(
  parameter int BANKS = 4,
  parameter int BA_W  = 2,
  parameter int TM_W  = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [TM_W-1:0] cfg_tras_i,
  input logic [TM_W-1:0] cfg_trp_i,
  input logic [TM_W-1:0] cfg_trcd_i,
  input logic [TM_W-1:0] cfg_trc_i,
  input logic [TM_W-1:0] cfg_twr_i,
  input logic            close_all_i,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic            cmd_valid_o,
  input logic            cmd_ras_n_o,
  input logic            cmd_cas_n_o,
  input logic            cmd_we_n_o,
  input logic [BA_W-1:0] cmd_bank_o,
  input logic            xfer_valid_o,
  input logic            xfer_ready_i,
  input logic [BA_W-1:0] xfer_bank_o,
  input logic            xfer_write_o
);
  localparam int CW = TM_W + 1;

  function automatic logic [CW-1:0] eff(input logic [TM_W-1:0] v);
    return (v == '0) ? CW'(1) : CW'(v);
  endfunction

  function automatic logic [CW-1:0] sat(input logic [CW-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  logic is_act, is_pre, wr_fire;
  logic [CW-1:0] since_act [BANKS];
  logic [CW-1:0] since_pre [BANKS];
  logic [CW-1:0] since_wr  [BANKS];
  logic [CW-1:0] since_any;

  assign is_act  = cmd_valid_o && !cmd_ras_n_o && cmd_cas_n_o && cmd_we_n_o;
  assign is_pre  = cmd_valid_o && !cmd_ras_n_o && cmd_cas_n_o && !cmd_we_n_o;
  assign wr_fire = xfer_valid_o && xfer_ready_i && xfer_write_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_any <= '1;
      for (int b = 0; b < BANKS; b++) begin
        since_act[b] <= '1;
        since_pre[b] <= '1;
        since_wr[b]  <= '1;
      end
    end else begin
      since_any <= is_act ? CW'(1) : sat(since_any);
      for (int b = 0; b < BANKS; b++) begin
        since_act[b] <= (is_act && cmd_bank_o == BA_W'(b)) ? CW'(1) : sat(since_act[b]);
        since_pre[b] <= ((is_pre && cmd_bank_o == BA_W'(b)) || close_all_i) ? CW'(1)
                        : sat(since_pre[b]);
        since_wr[b]  <= (wr_fire && xfer_bank_o == BA_W'(b)) ? CW'(1) : sat(since_wr[b]);
      end
    end
  end

  assert_nop_lines_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_o |-> (cmd_ras_n_o && cmd_cas_n_o && cmd_we_n_o));
  assert_cmd_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (is_act || is_pre));
  assert_tras_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |-> since_act[cmd_bank_o] >= eff(cfg_tras_i));
  assert_twr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |-> since_wr[cmd_bank_o] >= eff(cfg_twr_i));
  assert_trp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> since_pre[cmd_bank_o] >= eff(cfg_trp_i));
  assert_trc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> since_any >= eff(cfg_trc_i));
  assert_trcd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o |-> since_act[xfer_bank_o] >= eff(cfg_trcd_i));
  assert_single_req_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
endmodule

bind sdr_bank_mgr sbm_checker #(.BANKS(BANKS), .BA_W(BA_W), .TM_W(TM_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .cfg_tras_i(cfg_tras_i), .cfg_trp_i(cfg_trp_i), .cfg_trcd_i(cfg_trcd_i),
  .cfg_trc_i(cfg_trc_i), .cfg_twr_i(cfg_twr_i), .close_all_i(close_all_i),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .cmd_valid_o(cmd_valid_o), .cmd_ras_n_o(cmd_ras_n_o), .cmd_cas_n_o(cmd_cas_n_o),
  .cmd_we_n_o(cmd_we_n_o), .cmd_bank_o(cmd_bank_o),
  .xfer_valid_o(xfer_valid_o), .xfer_ready_i(xfer_ready_i),
  .xfer_bank_o(xfer_bank_o), .xfer_write_o(xfer_write_o)
);

// File: tb/sdr_bank_mgr_test.sv
module sdr_bank_mgr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  tras, trp, trcd, trc, twr;
  logic        close_all = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [11:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic [3:0]  req_len = '0;
  logic        cmd_valid, ras_n, cas_n, we_n;
  logic [1:0]  cmd_bank;
  logic [11:0] cmd_addr;
  logic        xfer_valid, xfer_ready = 1'b1, xfer_write;
  logic [1:0]  xfer_bank;
  logic [9:0]  xfer_col;
  logic [3:0]  xfer_len;

  always #4 clk = ~clk;

  sdr_bank_mgr uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_tras_i(tras), .cfg_trp_i(trp), .cfg_trcd_i(trcd), .cfg_trc_i(trc), .cfg_twr_i(twr),
    .close_all_i(close_all),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_bank_i(req_bank),
    .req_row_i(req_row), .req_col_i(req_col), .req_len_i(req_len), .req_write_i(req_write),
    .cmd_valid_o(cmd_valid), .cmd_ras_n_o(ras_n), .cmd_cas_n_o(cas_n), .cmd_we_n_o(we_n),
    .cmd_bank_o(cmd_bank), .cmd_addr_o(cmd_addr),
    .xfer_valid_o(xfer_valid), .xfer_ready_i(xfer_ready), .xfer_bank_o(xfer_bank),
    .xfer_col_o(xfer_col), .xfer_len_o(xfer_len), .xfer_write_o(xfer_write)
  );

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  bit stall = 0;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) xfer_ready <= !stall || (cyc % 3 != 0);

  // monitor state
  int acc_n = 0, acc_cyc, fwd_n = 0, fwd_cyc;
  int n_pre, n_act, n_code, pre_cyc, act_cyc, pre_bank, pre_addr, act_bank, act_row;
  int f_bank, f_col, f_len, f_wr;

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (req_valid && req_ready) begin
        acc_n++; acc_cyc = cyc; n_pre = 0; n_act = 0; n_code = 0;
      end
      if (cmd_valid) begin
        if (!ras_n && cas_n && we_n) begin
          n_act++; act_cyc = cyc; act_bank = int'(cmd_bank); act_row = int'(cmd_addr);
        end else if (!ras_n && cas_n && !we_n) begin
          n_pre++; pre_cyc = cyc; pre_bank = int'(cmd_bank); pre_addr = int'(cmd_addr);
        end else n_code++;
      end else if (!(ras_n && cas_n && we_n)) n_code++;
      if (xfer_valid && xfer_ready) begin
        fwd_n++; fwd_cyc = cyc; f_bank = int'(xfer_bank); f_col = int'(xfer_col);
        f_len = int'(xfer_len); f_wr = int'(xfer_write);
      end
    end
  end

  // reference model
  bit m_open[4];
  int m_row[4], l_act[4], l_pre[4], l_wr[4];
  int l_any, l_close;
  int c_ras, c_rp, c_rcd, c_rc, c_wr;

  function automatic int eff(int v); return (v == 0) ? 1 : v; endfunction
  function automatic int mx(int a, int b); return (a > b) ? a : b; endfunction
  function automatic bit ready_at(int c); return !stall || (c % 3 != 0); endfunction

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < 4; b++) begin
      m_open[b] = 0; m_row[b] = 0; l_act[b] = -1000; l_pre[b] = -1000; l_wr[b] = -1000;
    end
    l_any = -1000; l_close = -1000;
  endtask

  task automatic apply_cfg(input int ra, input int rp, input int rcd, input int rc,
                           input int wr, input bit st);
    @(negedge clk);
    rst_n = 0;
    tras = 4'(ra); trp = 4'(rp); trcd = 4'(rcd); trc = 4'(rc); twr = 4'(wr);
    c_ras = ra; c_rp = rp; c_rcd = rcd; c_rc = rc; c_wr = wr; stall = st;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
    @(negedge clk); #2;
    check(req_ready == 1'b1, "R13 ready after reset", int'(req_ready), 1);
    check(cmd_valid == 1'b0 && ras_n && cas_n && we_n, "R13 idle command lines",
          int'(cmd_valid), 0);
    check(xfer_valid == 1'b0, "R13 no transfer after reset", int'(xfer_valid), 0);
  endtask

  task automatic pulse_close();
    @(negedge clk);
    close_all = 1;
    l_close = cyc;
    @(negedge clk);
    close_all = 0;
    for (int b = 0; b < 4; b++) m_open[b] = 0;
  endtask

  task automatic do_req(input int b, input int row, input int col, input int len,
                        input bit wr, input string pfx);
    int a0, f0, t, e;
    bit hit, omiss;
    a0 = acc_n; f0 = fwd_n;
    @(negedge clk);
    req_valid = 1; req_bank = 2'(b); req_row = 12'(row); req_col = 10'(col);
    req_len = 4'(len); req_write = wr;
    @(posedge clk);
    while (acc_n == a0) @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    while (fwd_n == f0) @(posedge clk);

    hit   = m_open[b] && (m_row[b] == row);
    omiss = m_open[b] && (m_row[b] != row);
    t = acc_cyc + 1;
    if (omiss) begin
      e = mx(t, mx(l_act[b] + eff(c_ras), l_wr[b] + eff(c_wr)));
      check(n_pre == 1, {pfx, "R3 one precharge on row miss"}, n_pre, 1);
      check(pre_cyc == e, {pfx, "R5/R9 precharge cycle"}, pre_cyc, e);
      check(pre_bank == b && pre_addr == 0, {pfx, "R7 precharge bank/addr"},
            pre_bank * 4096 + pre_addr, b * 4096);
      l_pre[b] = pre_cyc;
      t = pre_cyc + 1;
    end else begin
      check(n_pre == 0, {pfx, "R2/R8 no precharge"}, n_pre, 0);
    end
    if (!hit) begin
      e = mx(t, mx(mx(l_pre[b], l_close) + eff(c_rp), l_any + eff(c_rc)));
      check(n_act == 1, {pfx, "R3/R8 one active"}, n_act, 1);
      check(act_cyc == e, {pfx, "R3/R6/R10 active cycle"}, act_cyc, e);
      check(act_bank == b && act_row == row, {pfx, "R7 active bank/row"},
            act_bank * 4096 + act_row, b * 4096 + row);
      l_act[b] = act_cyc; l_any = act_cyc; m_open[b] = 1; m_row[b] = row;
      t = act_cyc + 1;
    end else begin
      check(n_act == 0, {pfx, "R1/R2 hit issues no active"}, n_act, 0);
    end
    check(n_code == 0, {pfx, "R7 illegal command code"}, n_code, 0);
    e = mx(t, l_act[b] + eff(c_rcd));
    while (!ready_at(e)) e++;
    check(fwd_cyc == e, {pfx, "R4 handover cycle"}, fwd_cyc, e);
    check(f_bank == b && f_col == col && f_len == len && f_wr == int'(wr),
          {pfx, "R12 forwarded fields"}, f_bank * 100000 + f_col * 32 + f_len * 2 + f_wr,
          b * 100000 + col * 32 + len * 2 + int'(wr));
    if (wr) l_wr[b] = fwd_cyc;
  endtask

  int cfgs[6][5] = '{'{0, 0, 0, 0, 0}, '{3, 2, 2, 5, 2}, '{5, 3, 1, 7, 4},
                     '{1, 4, 3, 2, 1}, '{7, 1, 4, 9, 6}, '{2, 2, 2, 3, 3}};

  initial begin
    int unsigned s;
    string pfx;
    tras = 0; trp = 0; trcd = 0; trc = 0; twr = 0;
    s = 32'h1234_5678;
    for (int k = 0; k < 6; k++) begin
      // R11: configuration 0 programs every timing field to zero
      pfx = (k == 0) ? "R11 " : "";
      apply_cfg(cfgs[k][0], cfgs[k][1], cfgs[k][2], cfgs[k][3], cfgs[k][4], k == 5);
      // R1: open all banks with distinct rows, then revisit each
      for (int b = 0; b < 4; b++) do_req(b, b + 1, b * 7, b, (b % 2) == 1, pfx);
      for (int b = 0; b < 4; b++) do_req(b, b + 1, b * 9 + 1, 15 - b, 1'b0, pfx);
      for (int i = 0; i < 30; i++) begin
        s = s * 32'd1103515245 + 32'd12345;
        if (i == 15) pulse_close();  // R10
        do_req(int'((s >> 16) & 3), int'((s >> 18) % 3), int'((s >> 6) & 1023),
               int'((s >> 24) & 15), ((s >> 21) & 1) == 1, pfx);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule